// File: doc/BRIEF.md
# Dual-Rail Enable Sequencing Controller

This block is the digital control machine inside a two-channel linear regulator. Two enable pins ask for power on either rail. The block takes the supply lockout comparator, the handshakes from the reference and bypass circuits, and the ramp and target flags of each rail. From these it issues registered commands: shutdown, a single trim latch strobe, bandgap power, reference power, bypass fast-charge, and a turn-on command for each channel.

With both enables low the block is in shutdown. If either enable is high it waits for the supply to clear the upper lockout threshold. It then strobes trim and powers the bandgap for a fixed settle time. Next it powers the references and waits for them to report ready, then fast-charges the bypass node. Only after that does it release the rails. Channel 1 always has priority. Channel 2 is held back while channel 1 is requested and has not reached its target, unless channel 2 had already begun its ramp. If the supply falls below the lower lockout threshold, everything drops and the sequence restarts from the top.

Top module: `rail_seq_ctrl`

## Requirements
- R1: One cycle after both enables are sampled low, `shutdown` is 1 and every other command output is 0. Reset gives the same state.
- R2: With an enable high and `sup_above_rise` low, the block stays in lockout. `shutdown`, `trim_strobe`, `bg_pwr`, `ref_pwr`, `byp_fast` and both channel commands all stay 0.
- R3: After the supply clears lockout, commands follow this order: a `trim_strobe` pulse exactly one cycle wide; then `bg_pwr` alone for BG_SETTLE cycles; then `ref_pwr` held until `ref_ready`; then `byp_fast` held until `byp_charged`. After that, `byp_fast` drops and the channels may turn on. No channel command is ever high without `bg_pwr` and `ref_pwr`.
- R4: While both enables are high, channel 1 has not reached target and channel 2 has not started ramping, `ch2_on` is 0. It rises one cycle after `ch1_at_tgt` is sampled high.
- R5: If channel 1 is enabled while `ch2_on` is high but `ch2_ramping` is still low, `ch2_on` drops the next cycle while `ch1_on` rises. Channel 2 waits for channel 1's target.
- R6: If channel 1 is enabled after `ch2_ramping` is high, `ch1_on` rises the next cycle and `ch2_on` stays high.
- R7: When both enables are high as the rails are released, `ch1_on` rises before `ch2_on`.
- R8: In any state past lockout, sampling `sup_above_fall` low clears all power commands on the next cycle. The block then waits for `sup_above_rise` and reruns the full sequence, starting with a new `trim_strobe`.
- R9: Once past lockout, `sup_above_rise` going low while `sup_above_fall` stays high has no effect on any output.
- R10: Lowering one enable turns off only that channel's command, one cycle later. `bg_pwr` and `ref_pwr` stay high while the other enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_ch1 | input | 1 | Enable request for channel 1 |
| en_ch2 | input | 1 | Enable request for channel 2 |
| sup_above_rise | input | 1 | Supply is above the upper lockout threshold |
| sup_above_fall | input | 1 | Supply is above the lower lockout threshold |
| ref_ready | input | 1 | References report stable |
| byp_charged | input | 1 | Bypass node is charged |
| ch1_ramping | input | 1 | Channel 1 soft-start ramp has begun |
| ch1_at_tgt | input | 1 | Channel 1 output is at target |
| ch2_ramping | input | 1 | Channel 2 soft-start ramp has begun |
| ch2_at_tgt | input | 1 | Channel 2 output is at target |
| shutdown | output | 1 | Whole device off |
| trim_strobe | output | 1 | One-cycle trim latch strobe |
| bg_pwr | output | 1 | Bandgap power command |
| ref_pwr | output | 1 | Reference and current generator power command |
| byp_fast | output | 1 | Bypass fast-charge command |
| ch1_on | output | 1 | Channel 1 turn-on command |
| ch2_on | output | 1 | Channel 2 turn-on command |

## Verification
Every command output is registered from the next state, so a wrong internal phase shows at the ports on the very next clock. Examples are a skipped bandgap settle, a trim pulse that repeats, or a rail released before the bypass node is charged. Ordering faults show as `ch2_on` rising while channel 1 is still short of target, or dropping after its ramp has begun. A lockout fault shows as commands that survive one cycle past a low-supply sample. The bench runs a behavioural model beside the block and compares all seven commands every cycle, so any such divergence is caught within one clock.

// File: rtl/rail_seq_ctrl.sv
`timescale 1ns/1ps
module rail_seq_ctrl #(
  parameter int BG_SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_ch1,
  input  logic en_ch2,
  input  logic sup_above_rise,
  input  logic sup_above_fall,
  input  logic ref_ready,
  input  logic byp_charged,
  input  logic ch1_ramping,
  input  logic ch1_at_tgt,
  input  logic ch2_ramping,
  input  logic ch2_at_tgt,
  output logic shutdown,
  output logic trim_strobe,
  output logic bg_pwr,
  output logic ref_pwr,
  output logic byp_fast,
  output logic ch1_on,
  output logic ch2_on
);
  localparam int CW = $clog2(BG_SETTLE + 1);
  localparam logic [CW-1:0] BG_LAST = CW'(BG_SETTLE - 1);

  typedef enum logic [2:0] {S_OFF, S_WAIT, S_TRIM, S_BG, S_REF, S_CHG, S_RUN} st_t;

  st_t st, nx;
  logic [CW-1:0] bg_cnt;
  logic any_en, ch2_clear;

  assign any_en    = en_ch1 | en_ch2;
  assign ch2_clear = ch2_ramping | ~en_ch1 | ch1_at_tgt;

  always_comb begin
    nx = st;
    if (!any_en) nx = S_OFF;
    else begin
      case (st)
        S_OFF:   nx = S_WAIT;
        S_WAIT:  if (sup_above_rise) nx = S_TRIM;
        default: begin
          if (!sup_above_fall) nx = S_WAIT;
          else begin
            case (st)
              S_TRIM:  nx = S_BG;
              S_BG:    if (bg_cnt == BG_LAST) nx = S_REF;
              S_REF:   if (ref_ready) nx = S_CHG;
              S_CHG:   if (byp_charged) nx = S_RUN;
              default: nx = st;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_OFF;
      bg_cnt      <= '0;
      shutdown    <= 1'b1;
      trim_strobe <= 1'b0;
      bg_pwr      <= 1'b0;
      ref_pwr     <= 1'b0;
      byp_fast    <= 1'b0;
      ch1_on      <= 1'b0;
      ch2_on      <= 1'b0;
    end else begin
      st          <= nx;
      bg_cnt      <= (st == S_BG && nx == S_BG) ? bg_cnt + 1'b1 : '0;
      shutdown    <= (nx == S_OFF);
      trim_strobe <= (nx == S_TRIM);
      bg_pwr      <= (nx == S_BG) | (nx == S_REF) | (nx == S_CHG) | (nx == S_RUN);
      ref_pwr     <= (nx == S_REF) | (nx == S_CHG) | (nx == S_RUN);
      byp_fast    <= (nx == S_CHG);
      ch1_on      <= (nx == S_RUN) & en_ch1;
      ch2_on      <= (nx == S_RUN) & en_ch2 & ch2_clear;
    end
  end

  logic unused_ok;
  assign unused_ok = ch1_ramping | ch2_at_tgt;

  a_r1_idle_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ch1 && !en_ch2) |=> (shutdown && !bg_pwr && !ch1_on && !ch2_on));

  a_r2_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !sup_above_rise) |=> (!trim_strobe && !bg_pwr && !shutdown));

  a_r3_trim_single: assert property (@(posedge clk) disable iff (!rst_n)
    trim_strobe |=> !trim_strobe);

  a_r3_rails_need_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_on || ch2_on || byp_fast) |-> (bg_pwr && ref_pwr));

  a_r4_ch2_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ch1 && en_ch2 && !ch1_at_tgt && !ch2_ramping) |=> !ch2_on);

  a_r8_uv_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_OFF && st != S_WAIT && !sup_above_fall) |=>
      (!bg_pwr && !ref_pwr && !ch1_on && !ch2_on && !trim_strobe));

  a_r10_one_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && en_ch2 && !en_ch1 && sup_above_fall) |=> (ref_pwr && !ch1_on));
endmodule

// File: tb/rail_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rail_seq_ctrl_tb;
  localparam int BG = 4;
  logic clk = 0, rst_n = 0;
  logic e1 = 0, e2 = 0, rise = 0, fall = 0;
  logic refr = 0, byp = 0, r1 = 0, t1 = 0, r2 = 0, t2 = 0;
  logic sd, trim, bgp, refp, fast, c1, c2;
  int checks = 0, fails = 0, cyc = 0;
  int cr = 0, cb = 0, k1 = 0, k2 = 0;
  int ph = 0, bgn = 0;
  logic [6:0] xv;
  string tg [7] = '{"R10", "R4", "R3", "R3", "R3", "R2", "R1"};

  always #2.5 clk = ~clk;

  rail_seq_ctrl #(.BG_SETTLE(BG)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_ch1(e1), .en_ch2(e2),
    .sup_above_rise(rise), .sup_above_fall(fall),
    .ref_ready(refr), .byp_charged(byp),
    .ch1_ramping(r1), .ch1_at_tgt(t1), .ch2_ramping(r2), .ch2_at_tgt(t2),
    .shutdown(sd), .trim_strobe(trim), .bg_pwr(bgp), .ref_pwr(refp),
    .byp_fast(fast), .ch1_on(c1), .ch2_on(c2));

  // analog stand-in: handshakes follow the commands after fixed delays
  always @(negedge clk) begin
    cr = refp ? cr + 1 : 0;  refr = (cr >= 4);
    cb = fast ? cb + 1 : 0;  byp  = (cb >= 3);
    k1 = c1 ? k1 + 1 : 0;    r1 = (k1 >= 3); t1 = (k1 >= 6);
    k2 = c2 ? k2 + 1 : 0;    r2 = (k2 >= 3); t2 = (k2 >= 6);
  end

  // behavioural model: 0 off, 1 lockout, 2 trim, 3 bandgap, 4 refs, 5 charge, 6 run
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ph = 0; bgn = 0; end
    else begin
      if (!e1 && !e2) ph = 0;
      else if (ph == 0) ph = 1;
      else if (ph == 1) begin if (rise) ph = 2; end
      else if (!fall) ph = 1;
      else if (ph == 2) begin ph = 3; bgn = 0; end
      else if (ph == 3) begin bgn++; if (bgn == BG) ph = 4; end
      else if (ph == 4) begin if (refr) ph = 5; end
      else if (ph == 5) begin if (byp) ph = 6; end
    end
    xv[6] = (ph == 0);
    xv[5] = (ph == 2);
    xv[4] = (ph >= 3);
    xv[3] = (ph >= 4);
    xv[2] = (ph == 5);
    xv[1] = (ph == 6) && e1 && rst_n;
    xv[0] = (ph == 6) && e2 && (!e1 || r2 || t1) && rst_n;
  end

  always @(negedge clk) begin
    logic [6:0] av;
    av = {sd, trim, bgp, refp, fast, c1, c2};
    checks++;
    if (av !== xv) begin
      fails++;
      for (int i = 0; i < 7; i++)
        if (av[i] !== xv[i])
          $display("FAIL %s cycle %0d bit %0d actual=%b expected=%b", tg[6-i], cyc, i, av[i], xv[i]);
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    step(3);
    chk("R1 reset shutdown", sd, 1'b1);
    rst_n = 1;
    step(2);
    // R2: enable with supply low
    e1 = 1;
    step(10);
    chk("R2 no trim in lockout", trim, 1'b0);
    chk("R2 no bandgap in lockout", bgp, 1'b0);
    // R3: release supply and watch the sequence
    rise = 1; fall = 1;
    while (!trim) @(negedge clk);
    step(1);
    chk("R3 trim one cycle", trim, 1'b0);
    chk("R3 bandgap after trim", bgp, 1'b1);
    chk("R3 refs not yet", refp, 1'b0);
    // R9: upper flag drops mid-sequence
    rise = 0;
    while (!c1) @(negedge clk);
    chk("R9 rise loss ignored", refp, 1'b1);
    // R4: channel 2 requested before channel 1 at target
    e2 = 1;
    step(2);
    chk("R4 ch2 held", c2, 1'b0);
    while (!t1) @(negedge clk);
    step(1);
    chk("R4 ch2 after target", c2, 1'b1);
    // R10: drop channel 1 only
    e1 = 0;
    step(1);
    chk("R10 ch1 off", c1, 1'b0);
    chk("R10 ch2 stays", c2, 1'b1);
    chk("R10 refs stay", refp, 1'b1);
    // R1: drop both
    e2 = 0;
    step(1);
    chk("R1 shutdown", sd, 1'b1);
    chk("R1 refs off", refp, 1'b0);
    // R7: both together
    rise = 1;
    step(2);
    e1 = 1; e2 = 1;
    while (!c1 && !c2) @(negedge clk);
    chk("R7 ch1 first", c1, 1'b1);
    chk("R7 ch2 later", c2, 1'b0);
    step(12);
    e1 = 0; e2 = 0;
    step(2);
    // R5: ch1 request before ch2 ramp starts
    e2 = 1;
    while (!c2) @(negedge clk);
    e1 = 1;
    step(1);
    chk("R5 ch2 withdrawn", c2, 1'b0);
    chk("R5 ch1 on", c1, 1'b1);
    while (!t1) @(negedge clk);
    step(1);
    chk("R5 ch2 back after target", c2, 1'b1);
    e1 = 0; e2 = 0;
    step(2);
    // R6: ch1 request after ch2 ramp started
    e2 = 1;
    while (!r2) @(negedge clk);
    e1 = 1;
    step(1);
    chk("R6 ch1 at once", c1, 1'b1);
    chk("R6 ch2 kept", c2, 1'b1);
    step(8);
    // R8: supply collapse and recovery
    fall = 0; rise = 0;
    step(1);
    chk("R8 rails off", c1 | c2, 1'b0);
    chk("R8 bandgap off", bgp, 1'b0);
    step(5);
    chk("R8 still locked", trim, 1'b0);
    fall = 1; rise = 1;
    while (!trim) @(negedge clk);
    chk("R8 restart trim", trim, 1'b1);
    while (!c1) @(negedge clk);
    step(10);
    chk("R8 full restart both on", c1 & c2, 1'b1);
    e1 = 0; e2 = 0;
    step(3);
    summary();
  end
endmodule